// File: doc/BRIEF.md
# Secure Debug Region Gate

This block sits between a processor core's debug plumbing and its memory-protection unit. Each cycle it decides whether debug-related events must be suppressed because the current instruction, or the data address of a debugger-issued memory access, lies inside a protected region. The protection unit supplies one match flag per region for the instruction address and another set for the abstract-access address. A build-time mask marks which regions are protected, and a run-time enable input arms the protection as a whole.

Under protection, a debugger halt request is deferred and stays pending until execution leaves the region. A breakpoint instruction drops to an ordinary breakpoint exception instead of entering debug mode. Address-match trigger hits are discarded. The retired-instruction count and most performance counters freeze. A debugger load or store aimed at a protected address is refused with a bus-error code and makes no bus access. Every gated result is registered, so all outputs follow their inputs by exactly one clock.

Top module: `dsg_top`

## Requirements
- R1: A region counts as protected when the enable input `inhibit_en_i` is 1 and at least one match bit for a region whose bit in `INHIBIT_MASK` is 1 is set. When the enable input is 0, nothing is suppressed.
- R2: Every output is registered and reflects the inputs sampled at the previous rising clock edge.
- R3: A halt request is deferred while the instruction address is protected. Once the address is unprotected, `halt_o` pulses high for one cycle.
- R4: A deferred halt stays pending across cycles until it is issued or `halt_cancel_i` is asserted. A cancel in the same cycle as a request wins.
- R5: `ebreak_i` raises `ebreak_dbg_o` only when the address is unprotected and the enable bit for the current privilege is set. The privilege encodings are M=3 (bit 2 of `ebreak_en_i`), S=1 (bit 1) and U=0 (bit 0); code 2 enables nothing. In every other case it raises `ebreak_exc_o`.
- R6: Trigger hits pass through unchanged unless the instruction address is protected, in which case they are all dropped.
- R7: `instret_inc_o` follows `retire_i` except while the instruction address is protected, when it is 0.
- R8: Counter increment i is dropped while the address is protected, unless that counter's 4-bit event class (field i of `hpm_class_i`, bits 4i+3..4i) is 2, 3 or 5.
- R9: For an access request (`acc_valid_i`) whose address is protected, `acc_go_o` is 0 and `acc_err_o` is 3. An allowed request gives go=1 and err=0. With no request, both are 0.
- R10: While `rst` is high, all outputs are 0 and any pending halt is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inhibit_en_i | input | 1 | Global arm for region protection |
| pc_match_i | input | NUM_REGIONS | Region match flags for the instruction address |
| acc_match_i | input | NUM_REGIONS | Region match flags for the abstract-access address |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| ebreak_en_i | input | 3 | Breakpoint-to-debug enables {M,S,U} |
| ebreak_i | input | 1 | Breakpoint instruction executed |
| halt_req_i | input | 1 | Debugger halt request pulse |
| halt_cancel_i | input | 1 | Debugger withdraws the halt request |
| trig_hit_i | input | NUM_TRIG | Raw address-match trigger hits |
| retire_i | input | 1 | Instruction retired this cycle |
| hpm_inc_i | input | NUM_HPM | Raw performance counter increments |
| hpm_class_i | input | NUM_HPM*CLASS_W | Event class per counter |
| acc_valid_i | input | 1 | Abstract load/store request |
| halt_o | output | 1 | Halt issued to the core |
| ebreak_dbg_o | output | 1 | Breakpoint enters debug mode |
| ebreak_exc_o | output | 1 | Breakpoint raises an exception |
| trig_hit_o | output | NUM_TRIG | Gated trigger hits |
| instret_inc_o | output | 1 | Gated retired-instruction increment |
| hpm_inc_o | output | NUM_HPM | Gated counter increments |
| acc_go_o | output | 1 | Perform the bus access |
| acc_err_o | output | 3 | Access error code (0 ok, 3 bus error) |

## Verification
Every result of this block is due one clock after the inputs that produce it, including the halt issued on the first unprotected cycle after a deferral. The bench drives each stimulus on a falling edge and computes the expected outputs from its own model at that point, including a model of the pending halt. It then waits for the next falling edge, after the single register stage has updated, and compares all outputs there. Directed sequences cover these cases:
- a halt held across several protected cycles;
- a cancel issued while a halt is deferred;
- a reset issued while a halt is pending;
- the global enable switched off;
- each privilege level's breakpoint enable.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam logic [2:0] ACC_OK      = 3'd0;
  localparam logic [2:0] ACC_BUS_ERR = 3'd3;
endpackage

// File: rtl/dsg_region_eval.sv
module dsg_region_eval #(
  parameter int                     NUM_REGIONS  = 8,
  parameter logic [NUM_REGIONS-1:0] INHIBIT_MASK = '0
) (
  input  logic                   arm_i,
  input  logic [NUM_REGIONS-1:0] match_i,
  output logic                   prot_o
);
  logic [NUM_REGIONS-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < NUM_REGIONS; g++) begin : g_reg
      if (INHIBIT_MASK[g]) begin : g_on
        assign hit_vec[g] = match_i[g];
      end else begin : g_off
        assign hit_vec[g] = 1'b0;
      end
    end
  endgenerate

  assign prot_o = arm_i & (|hit_vec);
endmodule

// File: rtl/dsg_halt_defer.sv
module dsg_halt_defer (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic cancel_i,
  input  logic pc_prot_i,
  output logic halt_o
);
  logic pending_q;
  logic want;
  logic take;

  assign want = pending_q | req_i;
  assign take = want & ~cancel_i & ~pc_prot_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      halt_o    <= 1'b0;
    end else begin
      halt_o <= take;
      if (cancel_i || take) pending_q <= 1'b0;
      else                  pending_q <= want;
    end
  end

  // R3
  halt_outside_chk: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> $past(!pc_prot_i));

  // R4
  pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !cancel_i && pc_prot_i) |=> pending_q);

  // R4
  cancel_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cancel_i |=> (!pending_q && !halt_o));
endmodule

// File: rtl/dsg_event_gate.sv
module dsg_event_gate
  import dsg_pkg::*;
#(
  parameter int                       NUM_TRIG = 4,
  parameter int                       NUM_HPM  = 4,
  parameter int                       CLASS_W  = 4,
  parameter logic [(1<<CLASS_W)-1:0]  EXEMPT   = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pc_prot_i,
  input  logic [1:0]                 priv_i,
  input  logic [2:0]                 ebreak_en_i,
  input  logic                       ebreak_i,
  input  logic [NUM_TRIG-1:0]        trig_hit_i,
  input  logic                       retire_i,
  input  logic [NUM_HPM-1:0]         hpm_inc_i,
  input  logic [NUM_HPM*CLASS_W-1:0] hpm_class_i,
  output logic                       ebreak_dbg_o,
  output logic                       ebreak_exc_o,
  output logic [NUM_TRIG-1:0]        trig_hit_o,
  output logic                       instret_inc_o,
  output logic [NUM_HPM-1:0]         hpm_inc_o
);
  logic              mode_en;
  logic              to_dbg;
  logic [NUM_HPM-1:0] hpm_pass;

  always_comb begin
    case (priv_e'(priv_i))
      PRIV_M:  mode_en = ebreak_en_i[2];
      PRIV_S:  mode_en = ebreak_en_i[1];
      PRIV_U:  mode_en = ebreak_en_i[0];
      default: mode_en = 1'b0;
    endcase
  end

  assign to_dbg = ebreak_i & mode_en & ~pc_prot_i;

  genvar g;
  generate
    for (g = 0; g < NUM_HPM; g++) begin : g_hpm
      logic [CLASS_W-1:0] cls;
      assign cls         = hpm_class_i[g*CLASS_W +: CLASS_W];
      assign hpm_pass[g] = hpm_inc_i[g] & (~pc_prot_i | EXEMPT[cls]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ebreak_dbg_o  <= 1'b0;
      ebreak_exc_o  <= 1'b0;
      trig_hit_o    <= '0;
      instret_inc_o <= 1'b0;
      hpm_inc_o     <= '0;
    end else begin
      ebreak_dbg_o  <= to_dbg;
      ebreak_exc_o  <= ebreak_i & ~to_dbg;
      trig_hit_o    <= pc_prot_i ? '0 : trig_hit_i;
      instret_inc_o <= retire_i & ~pc_prot_i;
      hpm_inc_o     <= hpm_pass;
    end
  end

  // R5
  ebreak_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ebreak_dbg_o && ebreak_exc_o));

  // R5
  ebreak_prot_chk: assert property (@(posedge clk) disable iff (rst)
    (ebreak_i && pc_prot_i) |=> (ebreak_exc_o && !ebreak_dbg_o));

  // R6
  trig_drop_chk: assert property (@(posedge clk) disable iff (rst)
    pc_prot_i |=> (trig_hit_o == '0));

  // R7
  instret_chk: assert property (@(posedge clk) disable iff (rst)
    instret_inc_o |-> $past(retire_i && !pc_prot_i));

  // R8
  hpm_src_chk: assert property (@(posedge clk) disable iff (rst)
    (hpm_inc_o & ~$past(hpm_inc_i)) == '0);
endmodule

// File: rtl/dsg_access_guard.sv
module dsg_access_guard
  import dsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       valid_i,
  input  logic       acc_prot_i,
  output logic       go_o,
  output logic [2:0] err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      go_o  <= 1'b0;
      err_o <= ACC_OK;
    end else begin
      go_o  <= valid_i & ~acc_prot_i;
      err_o <= (valid_i & acc_prot_i) ? ACC_BUS_ERR : ACC_OK;
    end
  end

  // R9
  err_no_go_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o != ACC_OK) |-> !go_o);

  // R9
  blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && acc_prot_i) |=> (err_o == ACC_BUS_ERR && !go_o));
endmodule

// File: rtl/dsg_top.sv
module dsg_top #(
  parameter int                     NUM_REGIONS  = 8,
  parameter logic [NUM_REGIONS-1:0] INHIBIT_MASK = 8'b1010_0101,
  parameter int                     NUM_TRIG     = 4,
  parameter int                     NUM_HPM      = 4,
  parameter int                     CLASS_W      = 4,
  parameter logic [(1<<CLASS_W)-1:0] EXEMPT_CLASSES = 16'h002C
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inhibit_en_i,
  input  logic [NUM_REGIONS-1:0]     pc_match_i,
  input  logic [NUM_REGIONS-1:0]     acc_match_i,
  input  logic [1:0]                 priv_i,
  input  logic [2:0]                 ebreak_en_i,
  input  logic                       ebreak_i,
  input  logic                       halt_req_i,
  input  logic                       halt_cancel_i,
  input  logic [NUM_TRIG-1:0]        trig_hit_i,
  input  logic                       retire_i,
  input  logic [NUM_HPM-1:0]         hpm_inc_i,
  input  logic [NUM_HPM*CLASS_W-1:0] hpm_class_i,
  input  logic                       acc_valid_i,
  output logic                       halt_o,
  output logic                       ebreak_dbg_o,
  output logic                       ebreak_exc_o,
  output logic [NUM_TRIG-1:0]        trig_hit_o,
  output logic                       instret_inc_o,
  output logic [NUM_HPM-1:0]         hpm_inc_o,
  output logic                       acc_go_o,
  output logic [2:0]                 acc_err_o
);
  logic pc_prot;
  logic acc_prot;

  dsg_region_eval #(.NUM_REGIONS(NUM_REGIONS), .INHIBIT_MASK(INHIBIT_MASK)) u_pc_eval (
    .arm_i(inhibit_en_i), .match_i(pc_match_i), .prot_o(pc_prot)
  );

  dsg_region_eval #(.NUM_REGIONS(NUM_REGIONS), .INHIBIT_MASK(INHIBIT_MASK)) u_acc_eval (
    .arm_i(inhibit_en_i), .match_i(acc_match_i), .prot_o(acc_prot)
  );

  dsg_halt_defer u_halt (
    .clk(clk), .rst(rst), .req_i(halt_req_i), .cancel_i(halt_cancel_i),
    .pc_prot_i(pc_prot), .halt_o(halt_o)
  );

  dsg_event_gate #(
    .NUM_TRIG(NUM_TRIG), .NUM_HPM(NUM_HPM), .CLASS_W(CLASS_W), .EXEMPT(EXEMPT_CLASSES)
  ) u_events (
    .clk(clk), .rst(rst), .pc_prot_i(pc_prot), .priv_i(priv_i),
    .ebreak_en_i(ebreak_en_i), .ebreak_i(ebreak_i), .trig_hit_i(trig_hit_i),
    .retire_i(retire_i), .hpm_inc_i(hpm_inc_i), .hpm_class_i(hpm_class_i),
    .ebreak_dbg_o(ebreak_dbg_o), .ebreak_exc_o(ebreak_exc_o), .trig_hit_o(trig_hit_o),
    .instret_inc_o(instret_inc_o), .hpm_inc_o(hpm_inc_o)
  );

  dsg_access_guard u_acc (
    .clk(clk), .rst(rst), .valid_i(acc_valid_i), .acc_prot_i(acc_prot),
    .go_o(acc_go_o), .err_o(acc_err_o)
  );

  // R1
  disarmed_chk: assert property (@(posedge clk) disable iff (rst)
    !inhibit_en_i |-> (!pc_prot && !acc_prot));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!halt_o && !ebreak_dbg_o && !ebreak_exc_o && !acc_go_o));
endmodule

// File: tb/dsg_top_tb.sv
module dsg_top_tb;
  localparam int NR = 8;
  localparam int NT = 4;
  localparam int NH = 4;
  localparam int CW = 4;
  localparam logic [NR-1:0] MASK = 8'b1010_0101;

  logic clk = 1'b0;
  logic rst;
  logic inhibit_en_i;
  logic [NR-1:0] pc_match_i, acc_match_i;
  logic [1:0] priv_i;
  logic [2:0] ebreak_en_i;
  logic ebreak_i, halt_req_i, halt_cancel_i, retire_i, acc_valid_i;
  logic [NT-1:0] trig_hit_i;
  logic [NH-1:0] hpm_inc_i;
  logic [NH*CW-1:0] hpm_class_i;
  logic halt_o, ebreak_dbg_o, ebreak_exc_o, instret_inc_o, acc_go_o;
  logic [NT-1:0] trig_hit_o;
  logic [NH-1:0] hpm_inc_o;
  logic [2:0] acc_err_o;

  always #4 clk = ~clk;

  dsg_top #(.NUM_REGIONS(NR), .INHIBIT_MASK(MASK), .NUM_TRIG(NT), .NUM_HPM(NH), .CLASS_W(CW)) u_dut (
    .clk(clk), .rst(rst), .inhibit_en_i(inhibit_en_i), .pc_match_i(pc_match_i),
    .acc_match_i(acc_match_i), .priv_i(priv_i), .ebreak_en_i(ebreak_en_i),
    .ebreak_i(ebreak_i), .halt_req_i(halt_req_i), .halt_cancel_i(halt_cancel_i),
    .trig_hit_i(trig_hit_i), .retire_i(retire_i), .hpm_inc_i(hpm_inc_i),
    .hpm_class_i(hpm_class_i), .acc_valid_i(acc_valid_i), .halt_o(halt_o),
    .ebreak_dbg_o(ebreak_dbg_o), .ebreak_exc_o(ebreak_exc_o), .trig_hit_o(trig_hit_o),
    .instret_inc_o(instret_inc_o), .hpm_inc_o(hpm_inc_o), .acc_go_o(acc_go_o),
    .acc_err_o(acc_err_o)
  );

  int checks = 0;
  int fails  = 0;
  logic mpend;

  logic e_halt, e_dbg, e_exc, e_ret, e_go;
  logic [NT-1:0] e_trig;
  logic [NH-1:0] e_hpm;
  logic [2:0] e_err;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic prot(input logic en, input logic [NR-1:0] m);
    return en && ((m & MASK) != 0);
  endfunction

  function automatic logic exempt_cls(input logic [CW-1:0] c);
    return (c == 2) || (c == 3) || (c == 5);
  endfunction

  task automatic clear_inputs();
    inhibit_en_i = 0; pc_match_i = 0; acc_match_i = 0; priv_i = 2'd3;
    ebreak_en_i = 0; ebreak_i = 0; halt_req_i = 0; halt_cancel_i = 0;
    trig_hit_i = 0; retire_i = 0; hpm_inc_i = 0; hpm_class_i = 0; acc_valid_i = 0;
  endtask

  // compute expectations for current inputs, advance one clock, compare
  task automatic step();
    logic pi, ai, want, en_bit;
    pi = prot(inhibit_en_i, pc_match_i);
    ai = prot(inhibit_en_i, acc_match_i);
    if (rst) begin
      mpend = 0; e_halt = 0; e_dbg = 0; e_exc = 0; e_trig = 0; e_ret = 0;
      e_hpm = 0; e_go = 0; e_err = 0;
    end else begin
      want   = mpend | halt_req_i;
      e_halt = want && !halt_cancel_i && !pi;
      mpend  = (halt_cancel_i || e_halt) ? 1'b0 : want;
      case (priv_i)
        2'd3: en_bit = ebreak_en_i[2];
        2'd1: en_bit = ebreak_en_i[1];
        2'd0: en_bit = ebreak_en_i[0];
        default: en_bit = 1'b0;
      endcase
      e_dbg  = ebreak_i && en_bit && !pi;
      e_exc  = ebreak_i && !e_dbg;
      e_trig = pi ? '0 : trig_hit_i;
      e_ret  = retire_i && !pi;
      for (int i = 0; i < NH; i++)
        e_hpm[i] = hpm_inc_i[i] && (!pi || exempt_cls(hpm_class_i[i*CW +: CW]));
      e_go  = acc_valid_i && !ai;
      e_err = (acc_valid_i && ai) ? 3'd3 : 3'd0;
    end
    @(negedge clk);
    chk(rst ? "R10 halt" : "R3/R4 halt", halt_o, e_halt);
    chk("R5/R2 ebreak_dbg", ebreak_dbg_o, e_dbg);
    chk("R5 ebreak_exc", ebreak_exc_o, e_exc);
    chk("R6 trig", trig_hit_o, e_trig);
    chk("R7 instret", instret_inc_o, e_ret);
    chk("R8 hpm", hpm_inc_o, e_hpm);
    chk("R9 acc_go", acc_go_o, e_go);
    chk("R9 acc_err", acc_err_o, e_err);
  endtask

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC0DB6));
    mpend = 0;
    clear_inputs();
    rst = 1;
    @(negedge clk);
    // R10: reset state
    step(); step();
    rst = 0;
    step();

    // R3: halt deferred through protected cycles, issued once outside
    inhibit_en_i = 1; pc_match_i = 8'b0000_0100; halt_req_i = 1; step();
    halt_req_i = 0; step(); step();
    chk("R4 still held", halt_o, 1'b0);
    pc_match_i = 8'b0000_0010; step();   // unmasked region only
    chk("R3 issued", halt_o, 1'b1);
    pc_match_i = 0; step();
    chk("R3 single pulse", halt_o, 1'b0);

    // R4: cancel while deferred drops the request
    pc_match_i = 8'b1000_0000; halt_req_i = 1; step();
    halt_req_i = 0; halt_cancel_i = 1; step();
    halt_cancel_i = 0; pc_match_i = 0; step(); step();
    chk("R4 cancelled", halt_o, 1'b0);
    // R4: request and cancel together
    halt_req_i = 1; halt_cancel_i = 1; step();
    halt_req_i = 0; halt_cancel_i = 0; step();

    // R10: reset during pending halt
    pc_match_i = 8'b0000_0001; halt_req_i = 1; step();
    halt_req_i = 0; rst = 1; step();
    rst = 0; pc_match_i = 0; step(); step();

    // R1: disarmed -> no suppression
    inhibit_en_i = 0; pc_match_i = 8'hFF; acc_match_i = 8'hFF; retire_i = 1;
    trig_hit_i = 4'hF; acc_valid_i = 1; ebreak_i = 1; ebreak_en_i = 3'b111; step();
    chk("R1 disarmed go", acc_go_o, 1'b1);

    // R5: each privilege level, protected and not
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 8; b++) begin
        clear_inputs();
        inhibit_en_i = 1; priv_i = p[1:0]; ebreak_en_i = b[2:0]; ebreak_i = 1;
        step();
        pc_match_i = 8'b0010_0000; step();
      end
    end

    // R8: every class while protected
    for (int c = 0; c < 16; c++) begin
      clear_inputs();
      inhibit_en_i = 1; pc_match_i = 8'b0000_0100; hpm_inc_i = 4'hF;
      hpm_class_i = {4{c[3:0]}};
      step();
    end

    // random mix
    for (int n = 0; n < 4000; n++) begin
      inhibit_en_i  = ($urandom % 4) != 0;
      pc_match_i    = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      acc_match_i   = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      priv_i        = 2'($urandom);
      ebreak_en_i   = 3'($urandom);
      ebreak_i      = ($urandom % 4) == 0;
      halt_req_i    = ($urandom % 8) == 0;
      halt_cancel_i = ($urandom % 16) == 0;
      trig_hit_i    = 4'($urandom);
      retire_i      = 1'($urandom);
      hpm_inc_i     = 4'($urandom);
      hpm_class_i   = 16'($urandom);
      acc_valid_i   = 1'($urandom);
      rst           = ($urandom % 500) == 0;
      step();
    end
    rst = 0;
    clear_inputs();
    step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule